// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block sends the header that opens every frame a LIN master puts on the bus. A single write of an identifier byte starts it. The block then drives the serial line through three fields in a fixed order: a long dominant break with its recessive delimiter, the sync character 0x55, and the identifier character. Both characters use UART framing: one start bit at 0, eight data bits with the LSB first, and one stop bit at 1. Each bit lasts a number of system clock cycles set by a baud divisor input.

A ready output goes low when a write is accepted. It goes high again at the moment the identifier character is loaded for shifting. Two sticky flags mark the end of the break field and the end of the identifier field. A clear strobe resets both flags. An optional mode overwrites the two top identifier bits with the protected-identifier parity bits.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset, and whenever no header is in progress, `txd_o` is 1. After reset, `tx_rdy_o` is 1 and `brk_done_o` and `id_done_o` are 0.
- R2: A write (`id_wr_i` high) while idle starts a header. In the cycle after the write edge, `txd_o` is 0 and `tx_rdy_o` is 0.
- R3: Each bit lasts `baud_div_i` clock cycles. A divisor of 0 acts as 1.
- R4: The header begins with 13 bit times at 0, followed by one bit time at 1.
- R5: The sync field follows the break. It is a start bit at 0, the byte 0x55 sent LSB first, and a stop bit at 1.
- R6: The identifier field follows the sync field. It is a start bit, identifier bits 0 to 7 in order, and a stop bit. With `par_en_i` at 0, the byte is sent exactly as written.
- R7: With `par_en_i` at 1 when the write is accepted, bit 6 is sent as id0^id1^id2^id4 and bit 7 as NOT(id1^id3^id4^id5). Bits 5:0 are sent as written.
- R8: `tx_rdy_o` returns to 1 in the same cycle that the identifier start bit appears on `txd_o`.
- R9: `brk_done_o` goes to 1 in the cycle that follows the last delimiter bit time. It stays 1 until it is cleared.
- R10: `id_done_o` goes to 1 in the cycle that follows the identifier stop bit. In that same cycle the block returns to idle. The flag stays 1 until it is cleared.
- R11: `rst_sta_i` clears both sticky flags on the next edge. If a flag is set on the same edge as a clear, the set wins.
- R12: A write while a header is in progress is ignored. The bits on the line, the flags and `tx_rdy_o` are the same as without that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_div_i | input | DIV_W | Clock cycles per bit |
| par_en_i | input | 1 | Enable identifier parity insertion |
| id_wr_i | input | 1 | Identifier write strobe |
| id_data_i | input | 8 | Identifier byte |
| rst_sta_i | input | 1 | Clear both sticky flags |
| txd_o | output | 1 | Serial line, idles at 1 |
| tx_rdy_o | output | 1 | Ready for an identifier write |
| brk_done_o | output | 1 | Sticky flag: break field sent |
| id_done_o | output | 1 | Sticky flag: identifier field sent |

## Verification
A status clear and a flag set can land on the same clock edge. This happens once for the break-done flag at the end of the delimiter and once for the identifier-done flag at the end of the stop bit. The bench drives `rst_sta_i` so that it is sampled exactly on each of those edges. It then expects the flag being set to read 1, while the other flag, if it was already set, reads 0. Writes injected at random points inside a header also fall on shift and field-change edges. For those cases the bench checks that the bit stream, the ready line and the flags match the prediction with no write.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BRK  = 2'd1,
    ST_SYNC = 2'd2,
    ST_ID   = 2'd3
  } hdr_state_e;

  localparam int unsigned BRK_LOW = 13;
  localparam int unsigned SH_W    = BRK_LOW + 1;
  localparam int unsigned FRAME_W = 10;
  localparam logic [7:0]  SYNC_CHAR = 8'h55;
endpackage

// File: rtl/lin_hdr_baud.sv
module lin_hdr_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  // a divisor of 0 behaves as 1
  assign tick_o  = run_i && (cnt_nxt >= {1'b0, div_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (tick_o)             cnt_q <= '0;
    else                         cnt_q <= cnt_nxt[DIV_W-1:0];
  end
endmodule

// File: rtl/lin_hdr_pid.sv
module lin_hdr_pid (
  input  logic       par_en_i,
  input  logic [7:0] id_i,
  output logic [7:0] id_o
);
  logic p0, p1;
  assign p0   = id_i[0] ^ id_i[1] ^ id_i[2] ^ id_i[4];
  assign p1   = ~(id_i[1] ^ id_i[3] ^ id_i[4] ^ id_i[5]);
  assign id_o = par_en_i ? {p1, p0, id_i[5:0]} : id_i;
endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
  import lin_hdr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] id_i,
  input  logic       rst_sta_i,
  output logic       busy_o,
  output logic       txd_o,
  output logic       tx_rdy_o,
  output logic       brk_done_o,
  output logic       id_done_o
);
  localparam int unsigned CNT_W = $clog2(SH_W);

  hdr_state_e       state_q;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] bit_q;
  logic [7:0]       id_q;
  logic             last_bit, brk_set, id_set;

  function automatic logic [SH_W-1:0] frame(input logic [7:0] b);
    frame = {{(SH_W-FRAME_W){1'b1}}, 1'b1, b, 1'b0};
  endfunction

  assign busy_o   = (state_q != ST_IDLE);
  assign txd_o    = busy_o ? sh_q[0] : 1'b1;
  assign last_bit = (state_q == ST_BRK) ? (bit_q == CNT_W'(SH_W - 1))
                                        : (bit_q == CNT_W'(FRAME_W - 1));
  assign brk_set  = tick_i && last_bit && (state_q == ST_BRK);
  assign id_set   = tick_i && last_bit && (state_q == ST_ID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sh_q     <= '1;
      bit_q    <= '0;
      id_q     <= '0;
      tx_rdy_o <= 1'b1;
    end else if (start_i && !busy_o) begin
      state_q  <= ST_BRK;
      sh_q     <= {1'b1, {BRK_LOW{1'b0}}};
      bit_q    <= '0;
      id_q     <= id_i;
      tx_rdy_o <= 1'b0;
    end else if (tick_i && busy_o) begin
      if (!last_bit) begin
        sh_q  <= {1'b1, sh_q[SH_W-1:1]};
        bit_q <= bit_q + 1'b1;
      end else begin
        bit_q <= '0;
        unique case (state_q)
          ST_BRK: begin
            state_q <= ST_SYNC;
            sh_q    <= frame(SYNC_CHAR);
          end
          ST_SYNC: begin
            state_q  <= ST_ID;
            sh_q     <= frame(id_q);
            tx_rdy_o <= 1'b1;
          end
          default: begin
            state_q <= ST_IDLE;
            sh_q    <= '1;
          end
        endcase
      end
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_done_o <= 1'b0;
      id_done_o  <= 1'b0;
    end else begin
      if (brk_set)        brk_done_o <= 1'b1;
      else if (rst_sta_i) brk_done_o <= 1'b0;
      if (id_set)         id_done_o  <= 1'b1;
      else if (rst_sta_i) id_done_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             par_en_i,
  input  logic             id_wr_i,
  input  logic [7:0]       id_data_i,
  input  logic             rst_sta_i,
  output logic             txd_o,
  output logic             tx_rdy_o,
  output logic             brk_done_o,
  output logic             id_done_o
);
  logic       busy, tick, start;
  logic [7:0] pid;

  assign start = id_wr_i && !busy;

  lin_hdr_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy),
    .restart_i (start),
    .div_i     (baud_div_i),
    .tick_o    (tick)
  );

  lin_hdr_pid u_pid (
    .par_en_i (par_en_i),
    .id_i     (id_data_i),
    .id_o     (pid)
  );

  lin_hdr_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .start_i    (start),
    .id_i       (pid),
    .rst_sta_i  (rst_sta_i),
    .busy_o     (busy),
    .txd_o      (txd_o),
    .tx_rdy_o   (tx_rdy_o),
    .brk_done_o (brk_done_o),
    .id_done_o  (id_done_o)
  );
endmodule

// File: rtl/lin_hdr_tx_chk.sv
module lin_hdr_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic id_wr_i,
  input logic rst_sta_i,
  input logic txd_o,
  input logic tx_rdy_o,
  input logic brk_done_o,
  input logic id_done_o,
  input logic busy
);
  // R2
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_wr_i && !busy) |=> (!txd_o && !tx_rdy_o && busy));
  // R9
  brk_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_done_o && !rst_sta_i) |=> brk_done_o);
  // R10
  id_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_done_o && !rst_sta_i) |=> id_done_o);
  // R10
  id_end_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_done_o) |-> (txd_o && !busy && tx_rdy_o));
  // R11
  clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_sta_i && !busy) |=> (!brk_done_o && !id_done_o));
  // R12
  rdy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_rdy_o) |-> $past(id_wr_i && !busy));
endmodule

bind lin_hdr_tx lin_hdr_tx_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .id_wr_i    (id_wr_i),
  .rst_sta_i  (rst_sta_i),
  .txd_o      (txd_o),
  .tx_rdy_o   (tx_rdy_o),
  .brk_done_o (brk_done_o),
  .id_done_o  (id_done_o),
  .busy       (busy)
);

// File: tb/lin_hdr_tx_tb.sv
module lin_hdr_tx_tb_top;
  localparam int unsigned DIV_W = 16;
  localparam int HDR_BITS = 34;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [DIV_W-1:0] baud_div_i = '0;
  logic             par_en_i = 1'b0;
  logic             id_wr_i = 1'b0;
  logic [7:0]       id_data_i = '0;
  logic             rst_sta_i = 1'b0;
  logic             txd_o, tx_rdy_o, brk_done_o, id_done_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  lin_hdr_tx #(.DIV_W(DIV_W)) dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_id(input logic [7:0] id, input logic par);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return par ? {p1, p0, id[5:0]} : id;
  endfunction

  function automatic logic [HDR_BITS-1:0] exp_bits(input logic [7:0] id, input logic par);
    logic [HDR_BITS-1:0] v;
    v = '0;
    v[13] = 1'b1;
    v[23:14] = {1'b1, 8'h55, 1'b0};
    v[33:24] = {1'b1, exp_id(id, par), 1'b0};
    return v;
  endfunction

  function automatic string bit_req(input int b, input logic par);
    if (b < 14) return "R4";
    if (b < 24) return "R5";
    return par ? "R7" : "R6";
  endfunction

  task automatic clear_flags();
    @(negedge clk_i) rst_sta_i = 1'b1;
    @(negedge clk_i) rst_sta_i = 1'b0;
    check("R11 brk clear", brk_done_o, 1'b0);
    check("R11 id clear", id_done_o, 1'b0);
  endtask

  // inj_c >= 0 injects an ignored write at that cycle; coinc clears on flag-set edges
  task automatic run_hdr(input logic [7:0] id, input logic par, input int div,
                         input int inj_c, input bit coinc_brk, input bit coinc_id);
    int d;
    logic [HDR_BITS-1:0] v;
    d = (div == 0) ? 1 : div;
    v = exp_bits(id, par);
    clear_flags();
    baud_div_i = DIV_W'(div);
    par_en_i = par;
    id_data_i = id;
    id_wr_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    id_wr_i = 1'b0;
    par_en_i = ~par;
    id_data_i = ~id;
    check("R2 rdy low", tx_rdy_o, 1'b0);
    for (int c = 0; c < HDR_BITS * d; c++) begin
      // R3: bit index advances every d cycles
      check({"R3/", bit_req(c / d, par), " txd"}, txd_o, v[c / d]);
      check("R8 tx_rdy", tx_rdy_o, (c >= 24 * d));
      check("R9 brk_done", brk_done_o, (c >= 14 * d));
      check("R10 id_done", id_done_o, 1'b0);
      id_wr_i = (c == inj_c);
      rst_sta_i = (coinc_brk && c == 14 * d - 1) || (coinc_id && c == HDR_BITS * d - 1);
      @(negedge clk_i);
      id_wr_i = 1'b0;
      rst_sta_i = 1'b0;
    end
    check("R10 id_done set", id_done_o, 1'b1);
    check("R11 brk after clear", brk_done_o, coinc_id ? 1'b0 : 1'b1);
    check("R1 idle txd", txd_o, 1'b1);
    check("R1 idle rdy", tx_rdy_o, 1'b1);
    @(negedge clk_i);
    check("R10 id sticky", id_done_o, 1'b1);
  endtask

  initial begin
    void'($urandom(32'h1F3A));
    repeat (3) @(negedge clk_i);
    check("R1 reset txd", txd_o, 1'b1);
    check("R1 reset rdy", tx_rdy_o, 1'b1);
    check("R1 reset brk", brk_done_o, 1'b0);
    check("R1 reset id", id_done_o, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 idle txd", txd_o, 1'b1);

    run_hdr(8'h00, 1'b1, 1, -1, 1'b0, 1'b0);   // R7 parity on zero id
    run_hdr(8'hFF, 1'b0, 3, -1, 1'b0, 1'b0);   // R6 unchanged
    run_hdr(8'h3C, 1'b1, 0, -1, 1'b0, 1'b0);   // R3 divisor 0 as 1
    run_hdr(8'hA5, 1'b0, 2, -1, 1'b1, 1'b0);   // R11 set beats clear, brk
    run_hdr(8'h17, 1'b1, 2, -1, 1'b0, 1'b1);   // R11 set beats clear, id
    run_hdr(8'h5A, 1'b0, 4, 3, 1'b0, 1'b0);    // R12 early write ignored
    run_hdr(8'h2B, 1'b1, 2, 24 * 2 - 1, 1'b0, 1'b0); // R12 write on ID load edge
    run_hdr(8'h6E, 1'b0, 3, 30 * 3, 1'b0, 1'b0);     // R12 write during ID field

    for (int k = 0; k < 16; k++) begin
      logic [7:0] id;
      logic par;
      int div, inj;
      id = 8'($urandom);
      par = 1'($urandom);
      div = 1 + int'($urandom % 5);
      inj = ($urandom % 2) ? int'($urandom % (HDR_BITS * div - 1)) : -1;
      run_hdr(id, par, div, inj, 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule